// File: doc/BRIEF.md
# Burst SRAM Bank Controller

This controller sits between a 32-bit synchronous processor bus and a bank of fast static RAM. It sequences each bus cycle and counts the long-word position within a four-long-word line. It drives the RAM chip enable, the write strobe and the read data-buffer enable. It also returns a per-transfer termination acknowledge and a burst acknowledge, which tells the processor that another long word follows.

The first long word of a read takes three clocks by default. Driving `fast_mode` high shortens it to two clocks. Each further long word of a burst takes one clock. A burst is granted only when the line cannot wrap and the operand stays inside one long word. The processor can cut a burst short by dropping its burst request. Dropping the address strobe aborts the cycle at once. Writes are always single transfers.

The bank decodes a 1 Mbyte window, so a 256 Kbyte bank can grow to 1 Mbyte without any change to the decode.

Top module: `burst_sram_ctl`

## Requirements
- R1: The first termination acknowledge comes in the third clock of the cycle when `fast_mode` is 0, and in the second clock when it is 1. The clock in which `strobe` first rises counts as the first clock. `fast_mode` is sampled when the cycle starts.
- R2: After a beat whose `burst_ack` is high, the next beat follows one clock later. `burst_ack` is only ever high together with `term_ack`, and it marks that another beat follows.
- R3: `ram_addr[1:0]` holds the long-word index. It starts at `addr[3:2]` and rises by one after each beat that carries `burst_ack`.
- R4: A burst never wraps. The beat at long-word index 3 is always the last one, so a read that starts at index 3 is a single transfer.
- R5: Operand size `size` is encoded as 01 = 1 byte, 10 = 2, 11 = 3 and 00 = 4. When the last byte of the operand, `addr[1:0]` plus size minus 1, is past byte 3, the transfer is single and `burst_ack` stays low.
- R6: A write (`rd` = 0) is one transfer. It holds `ram_we` high, never raises `burst_ack`, and ends with `term_ack` after the R1 latency.
- R7: If `cbreq` is low during a beat, that beat is the last one.
- R8: While `strobe` is low, `ram_ce`, `ram_we`, `rd_buf_en`, `term_ack` and `burst_ack` are all low in the same clock. After reset, and after such an abort, the controller is idle and ready for a new cycle.
- R9: `rd_buf_en` is high only while the cycle is a selected read with `strobe` high, and it is low once the last beat is done.
- R10: `ram_ce` rises in the same clock as `strobe`, before any clock edge. It stays high through the last beat and drops after it, even if `strobe` stays high.
- R11: The bank is selected when `addr[31:20]` equals `BASE`. Bits 19:18 are not decoded. An unselected cycle produces no enable and no acknowledge.
- R12: `ram_addr[15:2]` always follows `addr[17:4]`, whether or not `strobe` is high. While idle, `ram_addr[1:0]` follows `addr[3:2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| strobe | input | 1 | Address strobe, active high |
| rd | input | 1 | 1 = read, 0 = write |
| cbreq | input | 1 | Processor burst request |
| fast_mode | input | 1 | 1 selects the 2-1-1-1 pattern |
| addr | input | 32 | Byte address |
| size | input | 2 | Operand size (01=1, 10=2, 11=3, 00=4 bytes) |
| ram_addr | output | 16 | Long-word address to the RAM |
| ram_ce | output | 1 | RAM chip enable |
| ram_we | output | 1 | RAM write strobe |
| rd_buf_en | output | 1 | Read data-buffer enable |
| term_ack | output | 1 | Per-transfer termination acknowledge |
| burst_ack | output | 1 | Burst acknowledge, another beat follows |

## Verification
The bench builds the controller with its default parameters. These are a three-clock slow first access, a two-clock fast one, a 64K-deep bank, a 1 Mbyte decode window and `BASE` = 0x00A. Because `fast_mode` is a port, both clock patterns can be reached in one build. The small line of four long words puts every start index within reach, from a full four-beat burst down to the forced single transfer at index 3. Random offsets and sizes reach the long-word crossing cases, and random address bits 19:18 reach the decode aliasing. Random burst-request drops and strobe aborts land on every beat position of a cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FIRST = 2'd1,
    ST_BURST = 2'd2,
    ST_DONE  = 2'd3
  } bsc_state_e;

  // Wait count compared against the first-access counter (starts at 0).
  function automatic int first_wait(input logic fast, input int slow_clks, input int fast_clks);
    return (fast ? fast_clks : slow_clks) - 2;
  endfunction

  // True when the operand spills past the end of its long word.
  function automatic logic crosses_lw(input logic [1:0] off, input logic [1:0] sz);
    logic [2:0] bytes;
    logic [2:0] stop;
    bytes = (sz == 2'b00) ? 3'd4 : {1'b0, sz};
    stop  = {1'b0, off} + bytes;
    return stop > 3'd4;
  endfunction

endpackage

// File: rtl/bsc_seq.sv
module bsc_seq
  import bsc_pkg::*;
#(
  parameter int SLOW_CLKS = 3,
  parameter int FAST_CLKS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strobe,
  input  logic       hit,
  input  logic       fast,
  input  logic       beat_more,
  output bsc_state_e state,
  output logic       start_evt,
  output logic       beat_evt
);
  localparam int CW = (SLOW_CLKS > 2) ? $clog2(SLOW_CLKS) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] tgt;

  assign start_evt = (state == ST_IDLE) && strobe && hit;
  assign beat_evt  = strobe && (((state == ST_FIRST) && (cnt == tgt)) || (state == ST_BURST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      tgt   <= '0;
    end else if (!strobe) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start_evt) begin
            state <= ST_FIRST;
            cnt   <= '0;
            tgt   <= CW'(first_wait(fast, SLOW_CLKS, FAST_CLKS));
          end
        end
        ST_FIRST: begin
          if (cnt == tgt) state <= beat_more ? ST_BURST : ST_DONE;
          else            cnt   <= cnt + 1'b1;
        end
        ST_BURST: begin
          if (!beat_more) state <= ST_DONE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bsc_lwcnt.sv
module bsc_lwcnt #(
  parameter int LW_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LW_W-1:0] ld_val,
  input  logic            inc,
  output logic [LW_W-1:0] lw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lw <= '0;
    else if (load) lw <= ld_val;
    else if (inc)  lw <= lw + 1'b1;
  end
endmodule

// File: rtl/bsc_gate.sv
module bsc_gate
  import bsc_pkg::*;
#(
  parameter int LW_W     = 2,
  parameter bit BURST_EN = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_evt,
  input  logic            rd,
  input  logic [1:0]      off,
  input  logic [1:0]      size,
  input  logic            cbreq,
  input  logic [LW_W-1:0] lw,
  input  logic            beat_evt,
  output logic            beat_more,
  output logic            burst_ack
);
  logic grant;

  generate
    if (BURST_EN) begin : g_burst
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         grant <= 1'b0;
        else if (start_evt) grant <= rd && !crosses_lw(off, size);
      end
    end else begin : g_single
      assign grant = 1'b0;
    end
  endgenerate

  // Line end (all-ones index) always closes the burst: no wraparound.
  assign beat_more = grant && cbreq && (lw != '1);
  assign burst_ack = beat_evt && beat_more;
endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
  import bsc_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int WIN_W     = 20,
  parameter int DEPTH_W   = 16,
  parameter int SLOW_CLKS = 3,
  parameter int FAST_CLKS = 2,
  parameter logic [ADDR_W-WIN_W-1:0] BASE = 12'h00A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               strobe,
  input  logic               rd,
  input  logic               cbreq,
  input  logic               fast_mode,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [1:0]         size,
  output logic [DEPTH_W-1:0] ram_addr,
  output logic               ram_ce,
  output logic               ram_we,
  output logic               rd_buf_en,
  output logic               term_ack,
  output logic               burst_ack
);
  localparam int LW_W = 2;

  bsc_state_e        state;
  logic              hit;
  logic              start_evt;
  logic              beat_evt;
  logic              beat_more;
  logic              active;
  logic [LW_W-1:0]   lw_cnt;
  logic [LW_W-1:0]   lw_sel;
  logic              unused_win;

  assign hit        = (addr[ADDR_W-1:WIN_W] == BASE);
  assign unused_win = ^addr[WIN_W-1:DEPTH_W+2];

  bsc_seq #(.SLOW_CLKS(SLOW_CLKS), .FAST_CLKS(FAST_CLKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .hit(hit), .fast(fast_mode),
    .beat_more(beat_more), .state(state), .start_evt(start_evt), .beat_evt(beat_evt)
  );

  bsc_lwcnt #(.LW_W(LW_W)) u_lw (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .ld_val(addr[3:2]),
    .inc(burst_ack), .lw(lw_cnt)
  );

  bsc_gate #(.LW_W(LW_W), .BURST_EN(1'b1)) u_gate (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .rd(rd), .off(addr[1:0]),
    .size(size), .cbreq(cbreq), .lw(lw_cnt), .beat_evt(beat_evt),
    .beat_more(beat_more), .burst_ack(burst_ack)
  );

  assign lw_sel    = (state == ST_IDLE) ? addr[3:2] : lw_cnt;
  assign ram_addr  = {addr[DEPTH_W+1:4], lw_sel};
  assign active    = strobe && hit && (state != ST_DONE);
  assign ram_ce    = active;
  assign ram_we    = active && !rd;
  assign rd_buf_en = active && rd;
  assign term_ack  = beat_evt;
endmodule

// File: rtl/bsc_chk.sv
module bsc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       strobe,
  input logic       rd,
  input logic       fast_mode,
  input logic       start_evt,
  input logic [1:0] lw_sel,
  input logic       ram_ce,
  input logic       ram_we,
  input logic       rd_buf_en,
  input logic       term_ack,
  input logic       burst_ack
);
  a_r8_quiet_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> !(ram_ce || ram_we || rd_buf_en || term_ack || burst_ack));

  a_r2_back_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    burst_ack |-> term_ack);

  a_r2_next_beat: assert property (@(posedge clk) disable iff (!rst_n)
    burst_ack |=> (!strobe || term_ack));

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    burst_ack |-> (lw_sel != 2'b11));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_ack && strobe) |=> (!strobe || (lw_sel == $past(lw_sel) + 2'd1)));

  a_r6_write_single: assert property (@(posedge clk) disable iff (!rst_n)
    (term_ack && !rd) |-> !burst_ack);

  a_r9_rdbuf_qual: assert property (@(posedge clk) disable iff (!rst_n)
    rd_buf_en |-> (strobe && rd && ram_ce));

  a_r10_ce_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    term_ack |-> ram_ce);

  a_r1_slow_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !fast_mode) |=> !term_ack);
endmodule

bind burst_sram_ctl bsc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd(rd), .fast_mode(fast_mode),
  .start_evt(start_evt), .lw_sel(lw_sel), .ram_ce(ram_ce), .ram_we(ram_we),
  .rd_buf_en(rd_buf_en), .term_ack(term_ack), .burst_ack(burst_ack)
);

// File: tb/sim_burst_sram_ctl.sv
module sim_burst_sram_ctl;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] BASE = 12'h00A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0, rd = 1'b0, cbreq = 1'b0, fast_mode = 1'b0;
  logic [31:0] addr = '0;
  logic [1:0]  size = 2'b00;
  logic [15:0] ram_addr;
  logic        ram_ce, ram_we, rd_buf_en, term_ack, burst_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram_ctl u0 (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rd(rd), .cbreq(cbreq),
    .fast_mode(fast_mode), .addr(addr), .size(size), .ram_addr(ram_addr),
    .ram_ce(ram_ce), .ram_we(ram_we), .rd_buf_en(rd_buf_en),
    .term_ack(term_ack), .burst_ack(burst_ack)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Last byte index of the operand; above 3 means it leaves the long word.
  function automatic bit spills(input logic [1:0] off, input logic [1:0] sz);
    int last;
    case (sz)
      2'b01:   last = int'(off);
      2'b10:   last = int'(off) + 1;
      2'b11:   last = int'(off) + 2;
      default: last = int'(off) + 3;
    endcase
    return last > 3;
  endfunction

  task automatic run_txn(input logic [31:0] a, input logic r, input logic [1:0] sz,
                         input logic f, input int drop_cb, input int abort_at);
    int  lat;
    bit  alive, grant, eack, eback;
    int  lw;
    lat   = f ? 2 : 3;
    alive = (a[31:20] == BASE);
    grant = r && !spills(a[1:0], sz);
    lw    = int'(a[3:2]);
    for (int idx = 0; idx <= lat + 5; idx++) begin
      @(negedge clk);
      if (idx == 0) begin
        addr = a; rd = r; size = sz; fast_mode = f; cbreq = 1'b1; strobe = 1'b1;
      end
      if (idx == drop_cb)  cbreq  = 1'b0;
      if (idx == abort_at) strobe = 1'b0;
      #1;
      if (idx >= abort_at) alive = 1'b0;
      eack  = alive && (idx >= lat - 1);
      eback = eack && grant && cbreq && (lw != 3);
      chk(ram_ce == alive, "R10 ram_ce (R11 decode, R8 abort)", int'(ram_ce), int'(alive));
      chk(ram_we == (alive && !r), "R6 ram_we", int'(ram_we), int'(alive && !r));
      chk(rd_buf_en == (alive && r), "R9 rd_buf_en", int'(rd_buf_en), int'(alive && r));
      chk(term_ack == eack, "R1 term_ack timing (R2 beats)", int'(term_ack), int'(eack));
      chk(burst_ack == eback, "R2 burst_ack (R4 wrap, R5 cross, R7 request)",
          int'(burst_ack), int'(eback));
      if (eack) chk(int'(ram_addr[1:0]) == lw, "R3 long-word index", int'(ram_addr[1:0]), lw);
      if (eack) begin
        if (eback) lw++;
        else       alive = 1'b0;
      end
    end
    @(negedge clk);
    strobe = 1'b0; cbreq = 1'b0;
    #1;
    chk(!(ram_ce || ram_we || rd_buf_en || term_ack || burst_ack), "R8 quiet after strobe low",
        int'({ram_ce, ram_we, rd_buf_en, term_ack, burst_ack}), 0);
    @(negedge clk);
    #1;
    chk(ram_addr[15:2] == a[17:4], "R12 upper address path", int'(ram_addr[15:2]), int'(a[17:4]));
    chk(ram_addr[1:0] == a[3:2], "R12 idle index follows addr", int'(ram_addr[1:0]), int'(a[3:2]));
  endtask

  function automatic logic [31:0] mk(input logic [11:0] up, input logic [19:0] lo);
    return {up, lo};
  endfunction

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd7741);
    repeat (3) @(negedge clk);
    #1;
    chk(!(ram_ce || term_ack || burst_ack || rd_buf_en || ram_we), "R8 reset state quiet",
        int'({ram_ce, ram_we, rd_buf_en, term_ack, burst_ack}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    run_txn(mk(BASE, 20'h00100), 1'b1, 2'b00, 1'b0, 99, 99); // R1 R2 slow 4-beat burst
    run_txn(mk(BASE, 20'h00200), 1'b1, 2'b00, 1'b1, 99, 99); // R1 fast 4-beat burst
    run_txn(mk(BASE, 20'h00304), 1'b1, 2'b00, 1'b0, 99, 99); // R3 start at index 1
    run_txn(mk(BASE, 20'h0040C), 1'b1, 2'b00, 1'b0, 99, 99); // R4 start at index 3
    run_txn(mk(BASE, 20'h00502), 1'b1, 2'b00, 1'b0, 99, 99); // R5 long at offset 2 crosses
    run_txn(mk(BASE, 20'h00503), 1'b1, 2'b01, 1'b1, 99, 99); // R5 byte at offset 3 ok
    run_txn(mk(BASE, 20'h00603), 1'b1, 2'b10, 1'b0, 99, 99); // R5 word at offset 3 crosses
    run_txn(mk(BASE, 20'h00700), 1'b0, 2'b00, 1'b0, 99, 99); // R6 write slow
    run_txn(mk(BASE, 20'h00710), 1'b0, 2'b00, 1'b1, 99, 99); // R6 write fast
    run_txn(mk(BASE, 20'h00800), 1'b1, 2'b00, 1'b0, 3, 99);  // R7 drop request in burst
    run_txn(mk(BASE, 20'h00900), 1'b1, 2'b00, 1'b0, 99, 3);  // R8 abort mid-burst
    run_txn(mk(BASE, 20'h00910), 1'b1, 2'b00, 1'b0, 99, 1);  // R8 abort before first beat
    run_txn(mk(12'h00B, 20'h00A00), 1'b1, 2'b00, 1'b0, 99, 99); // R11 miss
    run_txn(mk(BASE, 20'hC0B00), 1'b1, 2'b00, 1'b1, 99, 99); // R11 alias bits 19:18

    for (int n = 0; n < 120; n++) begin
      logic [11:0] up;
      up = (($urandom % 8) == 0) ? 12'(($urandom % 4096)) : BASE;
      run_txn(mk(up, 20'($urandom)), 1'($urandom), 2'($urandom), 1'($urandom),
              (($urandom % 3) == 0) ? int'($urandom % 8) : 99,
              (($urandom % 5) == 0) ? 1 + int'($urandom % 7) : 99);
    end

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule